// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one channel of a DMA controller. Software fills in a source address, a destination address, a byte count and a control word. Setting the enable bit then starts a copy, and the channel runs it on a memory-side request/acknowledge bus. Each side picks its own addressing style: a linear address that walks up or down, or a fixed FIFO port address. Each side also picks its own port width of 8, 16 or 32 bits. Bytes read from the narrower side are packed little-endian into a 32-bit holding word, or unpacked from it, so that a group as wide as the wider port moves per read/write exchange.

Copies run free when pacing is off. With pacing on, the channel waits for one chosen peripheral request line before each burst of a programmed number of bytes. A one-shot force bit stands in for that request once. A repeat bit makes the channel reload the programmed addresses and count at the end of a buffer and carry on, so software can stage the next buffer while the current one runs. An auto-clear bit drops repeat after that single reload. When the last buffer ends, a one-cycle done pulse is raised and the enable bit clears itself.

Top module: `dma_xfer_channel`

## Requirements
- R1: After reset every register reads zero. The register map is at cfg_addr offsets 0x00 source, 0x04 destination, 0x08 count (24 bits, upper bits dropped), 0x0C control, 0x10 request select, 0x14 burst length and 0x1C bytes moved. Offset 0x18 reads zero.
- R2: If the control enable bit 0 is set while idle and the programmed count is non-zero, the working addresses and count are loaded from the programmed registers and the copy starts. With pacing bit 3 clear, no request line is needed.
- R3: A linear side steps its address by its port width in bytes after every beat. It decrements when control bit 9 is set and increments otherwise.
- R4: Side mode fields are source bits 11:10 and destination bits 13:12. Code 2 is FIFO, where the address stays fixed for every beat. Code 3 behaves as FIFO, and codes 0 and 1 behave as linear.
- R5: Width fields are source bits 5:4 and destination bits 7:6, with 0 = 32-bit, 1 = 8-bit and 2 = 16-bit. mem_size gives log2 of the beat byte count. A group is as wide as the wider side: all of its reads come first, then all of its writes. Data sits in the low lanes, and bytes keep little-endian order through the holding word.
- R6: With pacing bit 3 set, each burst waits for periph_req at the index held in the request-select register. A burst runs until it has moved burst-length bytes or the count runs out. A burst length of 0 means 64 bytes.
- R7: Control bit 1 grants one burst without a request and clears itself when that grant is taken.
- R8: The bytes-moved register counts bytes written and restarts at zero on each start and on each reload.
- R9: When the count reaches zero with no reload due, done is high for exactly one cycle and enable bit 0 reads back zero. Enabling with a programmed count of zero gives the same pulse with no bus beat.
- R10: With repeat bit 2 set, the end of a buffer reloads source, destination and count from the programmed registers as they stand at that moment, and the channel continues without a done pulse. With auto-clear bit 14 also set, bit 2 is cleared at that reload.
- R11: Once mem_req is raised, mem_we, mem_addr, mem_size and mem_wdata stay stable until the cycle in which mem_ack is high.
- R12: If software clears enable bit 0 during a copy, the channel finishes the group in progress, then stops with no done pulse. The bytes-moved register keeps the bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| periph_req | input | NREQ | Peripheral request lines |
| mem_req | output | 1 | Bus beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat address |
| mem_size | output | 2 | log2 of the beat byte count |
| mem_wdata | output | 32 | Write data, low lanes |
| mem_ack | input | 1 | Beat accepted / read data valid |
| mem_rdata | input | 32 | Read data, low lanes |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Copies are run with equal 32-bit widths and with an 8-bit source feeding a 32-bit FIFO destination. A 32-bit FIFO source also feeds a decrementing 16-bit destination. Together these separate packing order, step size and step direction, and show whether a FIFO side holds its address. Paced runs use a 4-byte burst and the 64-byte default, with a distracting high request line left unselected. They show whether the channel stops exactly at burst edges and waits on the right line. Further runs cover the one-shot force, a repeat with registers rewritten mid-buffer, a zero-count start and an enable cleared mid-copy, which tell reload, auto-clear, end-of-copy and abort apart. The memory model answers with varying wait states, so every beat is compared against an independently built beat list.

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel #(
  parameter int NREQ   = 32,
  parameter int CNT_W  = 24,
  parameter int BLEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [NREQ-1:0]  periph_req,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [1:0]       mem_size,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             done
);
  localparam int REQ_W     = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int BL_W      = BLEN_W + 1;
  localparam int BURST_MAX = 1 << BLEN_W;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RD, S_WR, S_CHK} st_t;

  function automatic logic [2:0] wbytes(input logic [1:0] c);
    case (c)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] lg2(input logic [2:0] b);
    case (b)
      3'd1:    return 2'd0;
      3'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [31:0] bmask(input logic [2:0] b);
    case (b)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  st_t              st;
  logic [31:0]      src_prog, dst_prog, src_cur, dst_cur, hold;
  logic [CNT_W-1:0] cnt_prog, cnt_cur, ccnt;
  logic [14:0]      ctrl;
  logic [REQ_W-1:0] rsel;
  logic [BLEN_W-1:0] blen;
  logic [BL_W-1:0]  burst_left, blen_eff;
  logic [2:0]       gidx, sb, db, grp, rnext, wnext;
  logic             done_q, grant;
  logic [4:0]       sh;
  logic [31:0]      src_step, dst_step;

  assign sb       = wbytes(ctrl[5:4]);
  assign db       = wbytes(ctrl[7:6]);
  assign grp      = (sb > db) ? sb : db;
  assign rnext    = gidx + sb;
  assign wnext    = gidx + db;
  assign sh       = {gidx[1:0], 3'b000};
  assign grant    = !ctrl[3] || periph_req[rsel] || ctrl[1];
  assign blen_eff = (blen == '0) ? BL_W'(BURST_MAX) : {1'b0, blen};
  assign src_step = ctrl[11] ? src_cur : (ctrl[9] ? src_cur - 32'(sb) : src_cur + 32'(sb));
  assign dst_step = ctrl[13] ? dst_cur : (ctrl[9] ? dst_cur - 32'(db) : dst_cur + 32'(db));

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = mem_we ? dst_cur : src_cur;
  assign mem_size  = lg2(mem_we ? db : sb);
  assign mem_wdata = (hold >> sh) & bmask(db);
  assign done      = done_q;

  always_comb begin
    case (cfg_addr[4:2])
      3'd0:    cfg_rdata = src_prog;
      3'd1:    cfg_rdata = dst_prog;
      3'd2:    cfg_rdata = 32'(cnt_prog);
      3'd3:    cfg_rdata = 32'(ctrl);
      3'd4:    cfg_rdata = 32'(rsel);
      3'd5:    cfg_rdata = 32'(blen);
      3'd7:    cfg_rdata = 32'(ccnt);
      default: cfg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_prog <= '0; dst_prog <= '0; cnt_prog <= '0;
      ctrl <= '0; rsel <= '0; blen <= '0;
      src_cur <= '0; dst_cur <= '0; cnt_cur <= '0; ccnt <= '0;
      hold <= '0; gidx <= '0; burst_left <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr[4:2])
          3'd0: src_prog <= cfg_wdata;
          3'd1: dst_prog <= cfg_wdata;
          3'd2: cnt_prog <= cfg_wdata[CNT_W-1:0];
          3'd3: ctrl     <= cfg_wdata[14:0];
          3'd4: rsel     <= cfg_wdata[REQ_W-1:0];
          3'd5: blen     <= cfg_wdata[BLEN_W-1:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (ctrl[0]) begin
          if (cnt_prog == '0) begin
            done_q  <= 1'b1;
            ctrl[0] <= 1'b0;
          end else begin
            src_cur <= src_prog; dst_cur <= dst_prog; cnt_cur <= cnt_prog;
            ccnt <= '0; burst_left <= '0; gidx <= '0;
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!ctrl[0]) st <= S_IDLE;
          else if (grant) begin
            burst_left <= blen_eff;
            ctrl[1]    <= 1'b0;
            st         <= S_RD;
          end
        end
        S_RD: if (mem_ack) begin
          hold    <= (hold & ~(bmask(sb) << sh)) | ((mem_rdata & bmask(sb)) << sh);
          src_cur <= src_step;
          if (rnext >= grp) begin
            gidx <= '0;
            st   <= S_WR;
          end else gidx <= rnext;
        end
        S_WR: if (mem_ack) begin
          dst_cur <= dst_step;
          if (wnext >= grp) begin
            gidx       <= '0;
            cnt_cur    <= cnt_cur - CNT_W'(grp);
            ccnt       <= ccnt + CNT_W'(grp);
            burst_left <= (burst_left > BL_W'(grp)) ? burst_left - BL_W'(grp) : '0;
            st         <= S_CHK;
          end else gidx <= wnext;
        end
        S_CHK: begin
          if (cnt_cur == '0) begin
            if (ctrl[2] && cnt_prog != '0) begin
              src_cur <= src_prog; dst_cur <= dst_prog; cnt_cur <= cnt_prog;
              ccnt <= '0; burst_left <= '0;
              if (ctrl[14]) ctrl[2] <= 1'b0;
              st <= S_WAIT;
            end else begin
              done_q  <= 1'b1;
              ctrl[0] <= 1'b0;
              st      <= S_IDLE;
            end
          end else if (!ctrl[0])           st <= S_IDLE;
          else if (burst_left == '0)       st <= S_WAIT;
          else                             st <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  p_hold_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_size) && $stable(mem_wdata)));

  p_fifo_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && ctrl[11]) |=> $stable(src_cur));

  p_lin_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && !ctrl[13] && !ctrl[9])
      |=> dst_cur == $past(dst_cur) + 32'($past(db)));

  p_size_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3);

  p_paced_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && ctrl[0] && ctrl[3] && !ctrl[1] && !periph_req[rsel]) |=> !mem_req);
endmodule

// File: tb/tb_dma_xfer_channel.sv
`timescale 1ns/1ps
module tb_dma_xfer_channel;
  localparam int NREQ = 32;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_we, mem_req, mem_we, mem_ack, done;
  logic [4:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [1:0] mem_size;
  logic [NREQ-1:0] periph_req;

  dma_xfer_channel #(.NREQ(NREQ)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_req(periph_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done));

  logic [66:0] exp_q[$];
  integer n_cmp = 0, n_bad = 0, beats = 0, wr_beats = 0, done_cnt = 0;
  integer ridx = 0, m_ridx = 0, wait_ctr = 0;
  string cur_req = "R1";

  task automatic fail(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) fail(what, act, exp);
  endtask

  function automatic integer wb(input logic [1:0] c);
    return (c == 2'd1) ? 1 : (c == 2'd2) ? 2 : 4;
  endfunction

  function automatic logic [1:0] lg(input integer b);
    return (b == 1) ? 2'd0 : (b == 2) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [31:0] rpat(input logic [31:0] a, input integer idx);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'(a + 32'(k) + 32'(idx * 7));
    return r;
  endfunction

  function automatic logic [31:0] mk(input bit en, frc, rpt, ren, input logic [1:0] sw, dw,
                                     input bit dec, input logic [1:0] sm, dm, input bit acr);
    return {17'b0, acr, dm, sm, dec, 1'b0, dw, sw, ren, rpt, frc, en};
  endfunction

  task automatic gen(input logic [31:0] s0, d0, input integer cnt,
                     input logic [1:0] sw, dw, input bit sf, df, dec);
    integer sb, db, grp;
    logic [31:0] s, d, v;
    logic [7:0] by [0:3];
    sb = wb(sw); db = wb(dw); grp = (sb > db) ? sb : db; s = s0; d = d0;
    for (int g = 0; g < cnt / grp; g++) begin
      for (int r = 0; r < grp / sb; r++) begin
        v = rpat(s, m_ridx); m_ridx++;
        for (int k = 0; k < sb; k++) by[r*sb + k] = v[8*k +: 8];
        exp_q.push_back({1'b0, lg(sb), s, 32'h0});
        if (!sf) s = dec ? s - 32'(sb) : s + 32'(sb);
      end
      for (int w = 0; w < grp / db; w++) begin
        v = '0;
        for (int k = 0; k < db; k++) v[8*k +: 8] = by[w*db + k];
        exp_q.push_back({1'b1, lg(db), d, v});
        if (!df) d = dec ? d - 32'(db) : d + 32'(db);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      n_cmp++;
      if (exp_q.size() != 0) fail("done while beats pending", 32'(exp_q.size()), 32'h0);
    end
    if (mem_ack) mem_ack = 1'b0;
    else if (rst_n && mem_req) begin
      if (wait_ctr < beats % 3) wait_ctr++;
      else begin
        logic [66:0] e;
        wait_ctr = 0;
        if (exp_q.size() == 0) begin
          n_cmp++;
          fail("unexpected beat", mem_addr, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk("beat direction", 32'(mem_we), 32'(e[66]));
          chk("beat size", 32'(mem_size), 32'(e[65:64]));
          chk("beat address", mem_addr, e[63:32]);
          if (mem_we) chk("write data", mem_wdata, e[31:0]);
        end
        if (!mem_we) begin mem_rdata = rpat(mem_addr, ridx); ridx++; end
        else wr_beats++;
        beats++;
        mem_ack = 1'b1;
      end
    end
  end

  task automatic idle(input integer n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; #1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); cfg_addr = a; #1; v = cfg_rdata;
  endtask

  task automatic wait_done(input integer target);
    while (done_cnt < target) begin @(negedge clk); #1; end
  endtask

  task automatic wait_req_seen();
    while (!mem_req) begin @(negedge clk); #1; end
  endtask

  task automatic prog(input logic [31:0] s, d, c);
    wr(5'h00, s); wr(5'h04, d); wr(5'h08, c);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    integer d0, b0, w0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    periph_req = '0; mem_ack = 1'b0; mem_rdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state and register map
    cur_req = "R1";
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v);
      chk("reset register value", v, 32'h0);
    end
    chk("mem_req after reset", 32'(mem_req), 32'h0);
    chk("done after reset", 32'(done), 32'h0);
    wr(5'h10, 32'd5);   rd(5'h10, v); chk("request select readback", v, 32'd5);
    wr(5'h14, 32'h2A);  rd(5'h14, v); chk("burst length readback", v, 32'h2A);
    wr(5'h08, 32'h1FF_FFFF); rd(5'h08, v); chk("count is 24 bits", v, 32'hFF_FFFF);
    wr(5'h14, 32'h0);

    // R2 R3: free-running 32-bit linear increment copy
    cur_req = "R2";
    d0 = done_cnt;
    prog(32'h100, 32'h400, 32'd16);
    gen(32'h100, 32'h400, 16, 2'd0, 2'd0, 0, 0, 0);
    wr(5'h0C, mk(1,0,0,0, 2'd0,2'd0, 0, 2'd0,2'd0, 0));
    wait_done(d0 + 1);
    idle(2);
    chk("beats left after copy", 32'(exp_q.size()), 32'h0);
    cur_req = "R8";
    rd(5'h1C, v); chk("bytes moved", v, 32'd16);
    cur_req = "R9";
    rd(5'h0C, v); chk("enable self-clears", 32'(v[0]), 32'h0);

    // R5 R4: 8-bit linear source packed into 32-bit FIFO destination
    cur_req = "R5";
    d0 = done_cnt;
    prog(32'h1000, 32'h8000_0040, 32'd12);
    gen(32'h1000, 32'h8000_0040, 12, 2'd1, 2'd0, 0, 1, 0);
    wr(5'h0C, mk(1,0,0,0, 2'd1,2'd0, 0, 2'd0,2'd2, 0));
    wait_done(d0 + 1);
    idle(2);
    chk("packing beats left", 32'(exp_q.size()), 32'h0);

    // R4 R3: source mode 3 acts as FIFO, dest mode 1 acts as linear, decrement
    cur_req = "R4";
    d0 = done_cnt;
    prog(32'h2000, 32'h3000, 32'd8);
    gen(32'h2000, 32'h3000, 8, 2'd0, 2'd2, 1, 0, 1);
    wr(5'h0C, mk(1,0,0,0, 2'd0,2'd2, 1, 2'd3,2'd1, 0));
    wait_done(d0 + 1);
    idle(2);
    chk("mode/decrement beats left", 32'(exp_q.size()), 32'h0);

    // R6: paced, 4-byte bursts on line 5, line 3 high as distractor
    cur_req = "R6";
    d0 = done_cnt;
    periph_req[3] = 1'b1;
    wr(5'h10, 32'd5); wr(5'h14, 32'd4);
    prog(32'h7000, 32'h7800, 32'd16);
    gen(32'h7000, 32'h7800, 16, 2'd1, 2'd1, 0, 0, 0);
    b0 = beats;
    wr(5'h0C, mk(1,0,0,1, 2'd1,2'd1, 0, 2'd0,2'd0, 0));
    idle(30);
    chk("no beat without selected request", 32'(beats - b0), 32'h0);
    for (int i = 0; i < 4; i++) begin
      periph_req[5] = 1'b1;
      wait_req_seen();
      periph_req[5] = 1'b0;
      idle(50);
      chk("beats after paced burst", 32'(beats - b0), 32'(8 * (i + 1)));
    end
    wait_done(d0 + 1);
    periph_req[3] = 1'b0;

    // R6: burst length 0 means 64 bytes
    d0 = done_cnt;
    wr(5'h14, 32'd0);
    prog(32'h9000, 32'hA000, 32'd128);
    gen(32'h9000, 32'hA000, 128, 2'd1, 2'd1, 0, 0, 0);
    b0 = beats;
    wr(5'h0C, mk(1,0,0,1, 2'd1,2'd1, 0, 2'd0,2'd0, 0));
    periph_req[5] = 1'b1;
    wait_req_seen();
    periph_req[5] = 1'b0;
    idle(1000);
    chk("beats in a 64-byte burst", 32'(beats - b0), 32'd128);
    periph_req[5] = 1'b1;
    wait_req_seen();
    periph_req[5] = 1'b0;
    wait_done(d0 + 1);

    // R7: force grants a single burst
    cur_req = "R7";
    d0 = done_cnt;
    wr(5'h14, 32'd4);
    prog(32'hB000, 32'hC000, 32'd8);
    gen(32'hB000, 32'hC000, 8, 2'd1, 2'd1, 0, 0, 0);
    b0 = beats;
    wr(5'h0C, mk(1,0,0,1, 2'd1,2'd1, 0, 2'd0,2'd0, 0));
    idle(30);
    chk("stall before force", 32'(beats - b0), 32'h0);
    wr(5'h0C, mk(1,1,0,1, 2'd1,2'd1, 0, 2'd0,2'd0, 0));
    idle(50);
    chk("one burst per force", 32'(beats - b0), 32'd8);
    rd(5'h0C, v); chk("force self-clears", 32'(v[1]), 32'h0);
    wr(5'h0C, mk(1,1,0,1, 2'd1,2'd1, 0, 2'd0,2'd0, 0));
    wait_done(d0 + 1);

    // R10: repeat with auto-clear, registers rewritten during the first buffer
    cur_req = "R10";
    d0 = done_cnt;
    prog(32'h5000, 32'h6000, 32'd8);
    gen(32'h5000, 32'h6000, 8, 2'd2, 2'd2, 0, 0, 0);
    gen(32'h5100, 32'h6100, 6, 2'd2, 2'd2, 0, 0, 0);
    wr(5'h0C, mk(1,0,1,0, 2'd2,2'd2, 0, 2'd0,2'd0, 1));
    idle(2);
    prog(32'h5100, 32'h6100, 32'd6);
    wait_done(d0 + 1);
    idle(10);
    chk("single done across reload", 32'(done_cnt - d0), 32'd1);
    chk("reload beats left", 32'(exp_q.size()), 32'h0);
    rd(5'h0C, v); chk("auto-clear drops repeat", 32'(v[2]), 32'h0);
    cur_req = "R8";
    rd(5'h1C, v); chk("bytes moved restarts on reload", v, 32'd6);

    // R9: zero-count start
    cur_req = "R9";
    d0 = done_cnt; b0 = beats;
    wr(5'h08, 32'd0);
    wr(5'h0C, mk(1,0,0,0, 2'd0,2'd0, 0, 2'd0,2'd0, 0));
    idle(5);
    chk("zero-count done", 32'(done_cnt - d0), 32'd1);
    chk("zero-count beats", 32'(beats - b0), 32'h0);
    rd(5'h0C, v); chk("zero-count enable clears", 32'(v[0]), 32'h0);

    // R12: enable cleared mid-copy
    cur_req = "R12";
    d0 = done_cnt; w0 = wr_beats; b0 = beats;
    prog(32'hD000, 32'hE000, 32'd64);
    gen(32'hD000, 32'hE000, 64, 2'd1, 2'd1, 0, 0, 0);
    wr(5'h0C, mk(1,0,0,0, 2'd1,2'd1, 0, 2'd0,2'd0, 0));
    while (beats < b0 + 10) begin @(negedge clk); #1; end
    wr(5'h0C, mk(0,0,0,0, 2'd1,2'd1, 0, 2'd0,2'd0, 0));
    idle(30);
    chk("bus idle after abort", 32'(mem_req), 32'h0);
    chk("no done on abort", 32'(done_cnt - d0), 32'h0);
    rd(5'h1C, v); chk("bytes moved at abort", v, 32'(wr_beats - w0));
    b0 = beats;
    idle(20);
    chk("no beats after abort", 32'(beats - b0), 32'h0);
    exp_q.delete();

    summary();
    $finish;
  end
endmodule